// File: doc/BRIEF.md
# Dual-Bank Two-Wire EEPROM Slave

This block acts as the memory side of a two-wire serial EEPROM bus. It runs on a fast system clock and oversamples the SCL and SDA lines. It pulls SDA low only through an open-drain enable. Storage is split into two banks of 2048 bytes each. The upper nibble of the control byte selects the bank: 0xA picks the lower bank and 0xE picks the upper bank. Control bits 3:1 give the top three bits of the 11-bit byte address.

A bus master sets the address with a write-direction control byte followed by an address byte. It can then either stream data bytes into the selected bank, or issue a repeated start and read bytes back out. A read with no address phase continues from wherever the internal pointer last stopped. A debug port reads and writes the storage directly, so a testbench can preload the memory and inspect it.

Top module: `dual_bank_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start and moves the block to expect a control byte, from any state, including in the middle of a transfer. A rising SDA while SCL is high is a stop: it releases SDA and returns to idle. Bytes clocked without a preceding start get no acknowledge.
- R2: Data bits are taken on SCL rising edges, most significant bit first, eight per byte. Read data is shifted out most significant bit first.
- R3: A control byte with upper nibble 0xA selects bank 0, and upper nibble 0xE selects bank 1. Bit 0 = 0 means write and bit 0 = 1 means read. An accepted control byte is acknowledged.
- R4: A control byte with any other upper nibble is not acknowledged. Every byte after it is ignored, with no acknowledge and no memory change, until the next start.
- R5: In write direction, the byte after the control byte sets address bits 7:0, and control bits 3:1 set address bits 10:8. The address byte is acknowledged.
- R6: Each later written byte is stored at the current address of the selected bank and acknowledged. The address then increments modulo 2048 and stays in the same bank.
- R7: In read direction, the byte at the current address is sent and the address advances after its eighth bit. A master acknowledge (SDA low on the ninth clock) continues with the next byte. A master no-acknowledge stops all output until the next start. A read with no address phase continues from the current address, with bits 10:8 taken from the control byte.
- R8: A random read is a write control byte, then an address byte, then a repeated start with the read control byte. It returns data starting at the address just loaded.
- R9: Every byte of both banks holds 0xFF after power-up.
- R10: The acknowledge drive starts at the SCL falling edge after the eighth bit and ends at the SCL falling edge after the ninth clock. The block changes its SDA drive only while SCL is low, except when a stop or start forces a release.
- R11: The debug port writes a byte to {bank, address} when its write enable is high. It returns the byte stored at {bank, address} combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset of the bus logic |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, SDA is pulled low |
| dbg_bank | input | 1 | Debug port bank select |
| dbg_addr | input | 11 | Debug port byte address |
| dbg_we | input | 1 | Debug port write enable |
| dbg_wdata | input | 8 | Debug port write data |
| dbg_rdata | output | 8 | Debug port read data |

## Verification
A table of bank, address and data triples is written over the bus and read back in two ways: through the debug port and through bus random reads. The data values include single-bit patterns at either end of the byte, which separate most-significant-bit-first handling from reversed bit order. Writing the same address in both banks with different values shows whether the bank select is decoded. Directed runs cover a sequential write that wraps past address 0x7FF, a multi-byte read ended by a no-acknowledge, and a current-address read. Further runs check that a foreign control nibble and bytes sent without a start are refused, and that the acknowledge window sits on the ninth clock.

// File: rtl/dual_bank_eeprom_slave.sv
module dual_bank_eeprom_slave #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          dbg_bank,
  input  logic [AW-1:0] dbg_addr,
  input  logic          dbg_we,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(DW + 1);
  localparam int HB    = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDAT, S_RDAT, S_IGN} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall;

  st_t            st, nx_st;
  logic           bank;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  shreg, txd;
  logic [CW-1:0]  cnt;
  logic           ack_ph, ack_clk, mack, mack_ok;
  logic [DW-1:0]  mem [2*DEPTH];
  logic [DW-1:0]  rd_byte;
  logic           bus_we;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
  assign scl_rise  = scl_s && !scl_d;
  assign scl_fall  = !scl_s && scl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  initial begin
    for (int i = 0; i < 2*DEPTH; i++) mem[i] = '1;
  end

  assign rd_byte   = mem[{bank, addr}];
  assign dbg_rdata = mem[{dbg_bank, dbg_addr}];
  assign bus_we    = (st == S_WDAT) && scl_fall && !ack_ph && (cnt == CW'(DW)) &&
                     !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (bus_we) mem[{bank, addr}] <= shreg;
    if (dbg_we) mem[{dbg_bank, dbg_addr}] <= dbg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      nx_st   <= S_IDLE;
      bank    <= 1'b0;
      addr    <= '0;
      shreg   <= '0;
      txd     <= '0;
      cnt     <= '0;
      ack_ph  <= 1'b0;
      ack_clk <= 1'b0;
      mack    <= 1'b0;
      mack_ok <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det || stop_det) begin
      st      <= start_det ? S_CTRL : S_IDLE;
      cnt     <= '0;
      ack_ph  <= 1'b0;
      ack_clk <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      case (st)
        S_CTRL, S_ADDR, S_WDAT: begin
          if (scl_rise) begin
            if (ack_ph) ack_clk <= 1'b1;
            else if (cnt < CW'(DW)) begin
              shreg <= {shreg[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end
          end else if (scl_fall) begin
            if (ack_ph && ack_clk) begin
              ack_ph  <= 1'b0;
              ack_clk <= 1'b0;
              cnt     <= '0;
              st      <= nx_st;
              if (nx_st == S_RDAT) begin
                txd    <= rd_byte;
                sda_oe <= ~rd_byte[DW-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end else if (!ack_ph && cnt == CW'(DW)) begin
              cnt <= '0;
              case (st)
                S_CTRL: begin
                  if (shreg[7:4] == 4'hA || shreg[7:4] == 4'hE) begin
                    bank           <= shreg[6];
                    addr[AW-1:DW]  <= shreg[HB:1];
                    nx_st          <= shreg[0] ? S_RDAT : S_ADDR;
                    ack_ph         <= 1'b1;
                    sda_oe         <= 1'b1;
                  end else begin
                    st <= S_IGN;
                  end
                end
                S_ADDR: begin
                  addr   <= {addr[AW-1:DW], shreg};
                  nx_st  <= S_WDAT;
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                end
                default: begin
                  addr   <= addr + 1'b1;
                  nx_st  <= S_WDAT;
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                end
              endcase
            end
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            if (mack) begin
              ack_clk <= 1'b1;
              mack_ok <= !sda_s;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (scl_fall) begin
            if (mack) begin
              if (ack_clk) begin
                mack    <= 1'b0;
                ack_clk <= 1'b0;
                if (mack_ok) begin
                  txd    <= rd_byte;
                  sda_oe <= ~rd_byte[DW-1];
                  cnt    <= '0;
                end else begin
                  st <= S_IGN;
                end
              end
            end else if (cnt == CW'(DW)) begin
              sda_oe <= 1'b0;
              addr   <= addr + 1'b1;
              mack   <= 1'b1;
            end else begin
              txd    <= {txd[DW-2:0], 1'b0};
              sda_oe <= ~txd[DW-2];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_bank_eeprom_slave_chk.sv
module dual_bank_eeprom_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic [2:0] st,
  input logic [3:0] cnt
);
  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s)); // R10
  AST_RELEASE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R10
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == 3'd0) && !sda_oe); // R1
  AST_START_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == 3'd1)); // R1
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |-> !sda_oe); // R4
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8); // R2
endmodule

bind dual_bank_eeprom_slave dual_bank_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .st(st), .cnt(cnt)
);

// File: tb/sim_dual_bank_eeprom_slave.sv
`timescale 1ns/1ps
module sim_dual_bank_eeprom_slave;
  localparam int Q = 12;
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 11'h005, 8'h80}, {1'b1, 11'h005, 8'h01}, {1'b0, 11'h3A7, 8'h5A},
    {1'b1, 11'h6C3, 8'hA5}, {1'b0, 11'h7FF, 8'h3C}, {1'b1, 11'h100, 8'hC3}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, m_scl, m_sda, sda_oe, dbg_bank, dbg_we;
  logic [10:0] dbg_addr;
  logic [7:0] dbg_wdata, dbg_rdata;
  wire sda_line = m_sda & ~sda_oe;
  int n_chk = 0, n_bad = 0;

  dual_bank_eeprom_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dbg_bank(dbg_bank), .dbg_addr(dbg_addr), .dbg_we(dbg_we),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctl(input logic b, input logic [10:0] a, input logic rd);
    return {(b ? 4'hE : 4'hA), a[10:8], rd};
  endfunction

  task automatic bstart();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack, output logic win);
    logic held, rel;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q);
    end
    held = sda_oe;
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    ack = !sda_line;
    m_scl = 1'b0; wt(Q);
    rel = sda_oe;
    win = held && !rel;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b1; wt(Q); b[i] = sda_line; m_scl = 1'b0; wt(Q);
    end
    m_sda = !mack; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic bd_read(input logic b, input logic [10:0] a, output logic [7:0] d);
    dbg_bank = b; dbg_addr = a; wt(1); d = dbg_rdata;
  endtask

  task automatic bd_write(input logic b, input logic [10:0] a, input logic [7:0] d);
    dbg_bank = b; dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1; wt(1); dbg_we = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack, win;
    logic [7:0] d;
    logic b;
    logic [10:0] a;
    logic [7:0] dv;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    dbg_bank = 1'b0; dbg_addr = '0; dbg_we = 1'b0; dbg_wdata = '0;
    wt(10); rst_n = 1'b1; wt(10);

    chk("R1 reset sda_oe", sda_oe, 0);
    bd_read(1'b0, 11'h000, d); chk("R9 bank0 erased", d, 8'hFF);
    bd_read(1'b1, 11'h7FF, d); chk("R9 bank1 erased", d, 8'hFF);

    for (int v = 0; v < NV; v++) begin
      {b, a, dv} = VEC[v];
      bstart();
      wbyte(ctl(b, a, 1'b0), ack, win);
      chk("R3 control ack", ack, 1); chk("R10 ack window", win, 1);
      wbyte(a[7:0], ack, win); chk("R5 address ack", ack, 1);
      wbyte(dv, ack, win); chk("R6 data ack", ack, 1);
      bstop();
      bd_read(b, a, d); chk("R5 R2 R11 stored byte", d, dv);
    end
    for (int v = 0; v < NV; v++) begin
      {b, a, dv} = VEC[v];
      bstart();
      wbyte(ctl(b, a, 1'b0), ack, win);
      wbyte(a[7:0], ack, win);
      bstart();
      wbyte(ctl(b, a, 1'b1), ack, win); chk("R3 read control ack", ack, 1);
      rbyte(1'b0, d); chk("R8 R2 random read", d, dv);
      bstop();
    end

    bstart();
    wbyte(ctl(1'b1, 11'h7FE, 1'b0), ack, win);
    wbyte(8'hFE, ack, win);
    wbyte(8'hD1, ack, win); wbyte(8'hD2, ack, win);
    wbyte(8'hD3, ack, win); chk("R6 wrapped write ack", ack, 1);
    bstop();
    bd_read(1'b1, 11'h7FE, d); chk("R6 seq 7FE", d, 8'hD1);
    bd_read(1'b1, 11'h7FF, d); chk("R6 seq 7FF", d, 8'hD2);
    bd_read(1'b1, 11'h000, d); chk("R6 wrap to 000", d, 8'hD3);
    bd_read(1'b0, 11'h000, d); chk("R6 other bank untouched", d, 8'hFF);

    bd_write(1'b0, 11'h100, 8'h11); bd_write(1'b0, 11'h101, 8'h22);
    bd_write(1'b0, 11'h102, 8'h33); bd_write(1'b0, 11'h103, 8'h44);
    bstart();
    wbyte(ctl(1'b0, 11'h100, 1'b0), ack, win);
    wbyte(8'h00, ack, win);
    bstart();
    wbyte(ctl(1'b0, 11'h100, 1'b1), ack, win);
    rbyte(1'b1, d); chk("R11 R8 preload byte 0", d, 8'h11);
    rbyte(1'b1, d); chk("R7 acked next byte", d, 8'h22);
    rbyte(1'b0, d); chk("R7 third byte", d, 8'h33);
    rbyte(1'b0, d); chk("R7 silent after nack", d, 8'hFF);
    bstop();
    bstart();
    wbyte(ctl(1'b0, 11'h100, 1'b1), ack, win); chk("R7 current read ack", ack, 1);
    rbyte(1'b0, d); chk("R7 current address read", d, 8'h44);
    bstop();

    bstart();
    wbyte(8'hB0, ack, win); chk("R4 foreign control nack", ack, 0);
    chk("R4 no drive in ack slot", win, 0);
    wbyte(8'h00, ack, win); chk("R4 later byte nack", ack, 0);
    wbyte(8'h77, ack, win); chk("R4 data byte nack", ack, 0);
    bstop();
    bd_read(1'b0, 11'h000, d); chk("R4 bank0 unchanged", d, 8'hFF);
    bd_read(1'b1, 11'h000, d); chk("R4 bank1 unchanged", d, 8'hD3);

    m_scl = 1'b0; wt(Q);
    wbyte(ctl(1'b0, 11'h000, 1'b0), ack, win); chk("R1 no start no ack", ack, 0);
    bstop();

    bstart();
    wbyte(ctl(1'b0, 11'h000, 1'b0), ack, win);
    wbyte(8'h40, ack, win);
    bstart();
    wbyte(ctl(1'b0, 11'h040, 1'b0), ack, win); chk("R1 repeated start recontrol", ack, 1);
    wbyte(8'h41, ack, win);
    wbyte(8'h9C, ack, win);
    bstop();
    bd_read(1'b0, 11'h041, d); chk("R1 R5 write after restart", d, 8'h9C);
    bd_read(1'b0, 11'h040, d); chk("R1 old address untouched", d, 8'hFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule